// File: doc/BRIEF.md
# Received Signal Strength Estimator with S-Meter Code

This block turns a stream of signed I/Q baseband samples into a signal-strength estimate. Each strobe feeds one I/Q pair and a transmit-active flag. Each channel's absolute value goes into a shift-based leaky integrator. The integrator keeps its state scaled up by `LSH` bits, so the long-term level is held to higher precision than the input.

The two smoothed levels are combined into an approximate vector length. The larger level is compared with a weighted sum built from shifts: 29/32 of the larger level plus 61/128 of the smaller. That length becomes the RSSI word. The RSSI is quantized into a two-digit S-meter code, and a restoring divider forms a receive gain factor equal to a fixed constant divided by RSSI. When the transmitter is active, the integrators keep running but the published results stay frozen.

Top module: `rssi_meter`

## Requirements
- R1: On each `smp_valid` strobe, each channel level L is updated to L + |x| − (L >> LSH). |x| is the absolute value of the sample, and the most negative code saturates to the largest positive code. Levels start at 0 after reset.
- R2: The vector length is built from the larger level (hi) and the smaller level (lo). It is max(hi, T) >> LSH, where T = hi>>1 + hi>>2 + hi>>3 + hi>>5 + lo>>2 + lo>>3 + lo>>4 + lo>>5 + lo>>7, and each term is truncated before the sum.
- R3: A vector length of 0 is published as RSSI 1, so `rssi` never reads 0 and the divisor is never 0.
- R4: `s_code` is binary-coded. It is 1 when RSSI ≤ 4. Otherwise it is the largest n in 2..9 with RSSI > 2^n, so for example 512 gives 8 and 513 gives 9.
- R5: Above the S9 range, `s_code` is 91, 92, 93 or 94 when RSSI is strictly greater than 1618, 5120, 16180 or 51200 respectively. The highest threshold exceeded wins.
- R6: `rx_gain` equals floor(GAIN_TOP / RSSI), where RSSI is the value published with it.
- R7: A strobe taken with `tx_active` high still updates both levels. It produces no `out_valid` pulse, and `rssi`, `s_code` and `rx_gain` keep their values.
- R8: For a strobe taken with `tx_active` low, `out_valid` is a one-cycle pulse that rises on the (GAIN_W+2)-th rising edge after the edge that sampled the strobe. `rssi`, `s_code` and `rx_gain` change together on that same edge and at no other time.
- R9: While `rst_n` is low at a clock edge, both levels clear to 0, `rssi` becomes 1, `s_code` becomes 1, `rx_gain` becomes GAIN_TOP and `out_valid` goes low.
- R10: Strobes may be spaced as closely as GAIN_W+1 cycles. A strobe sampled on the same edge that publishes the previous result loses neither result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle sample strobe |
| smp_i | input | SMP_W | In-phase sample, two's complement |
| smp_q | input | SMP_W | Quadrature sample, two's complement |
| tx_active | input | 1 | Transmitter active, sampled with the strobe |
| out_valid | output | 1 | Pulse marking a new published result |
| rssi | output | ACC_W | Signal strength estimate, at least 1 |
| s_code | output | 7 | S-meter code 1..9 or 91..94 |
| rx_gain | output | GAIN_W | GAIN_TOP divided by `rssi` |

## Verification
Two of the block's functions can land on the same clock edge. A new sample can enter the level integrators on the edge where the divider's previous quotient is being published. The bench provokes this by spacing strobes exactly GAIN_W+2 and GAIN_W+1 cycles apart. The scoreboard then requires every queued result to arrive with its own RSSI, code and gain, at the edge its own strobe predicts.

// File: rtl/rssi_pkg.sv
// Shared constants for the signal strength estimator.
// Assumes: S-meter codes fit in 7 bits (largest code is 94).
package rssi_pkg;
    localparam int CODE_W = 7;
    typedef logic [CODE_W-1:0] scode_t;

    // Binary region: code rises by one each time RSSI doubles past 4..512
    localparam int BIN_STEPS = 8;
    localparam int BIN_FIRST_EXP = 2;

    // Upper region: roughly 10 dB steps over the S9 level
    localparam int DB_STEPS = 4;
    localparam int unsigned DB_LIMIT [DB_STEPS] = '{1618, 5120, 16180, 51200};
    localparam int DB_BASE_CODE = 90;
endpackage

// File: rtl/rssi_level_filter.sv
// Leaky integrator for one channel: level += |x| - (level >> LSH).
// Assumes: ACC_W is wide enough for (2^(SMP_W-1)-1) << LSH.
// The most negative input saturates to the largest positive magnitude.
module rssi_level_filter #(
    parameter int SMP_W = 16,
    parameter int ACC_W = 32,
    parameter int LSH   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp,
    output logic        [ACC_W-1:0] level
);
    localparam logic [SMP_W-1:0] MOST_NEG = {1'b1, {(SMP_W-1){1'b0}}};
    localparam logic [SMP_W-1:0] MOST_POS = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] LEVEL_CAP = ACC_W'(MOST_POS) << LSH;

    logic [SMP_W-1:0] abs_val;

    // Purpose: saturating absolute value of the incoming sample
    always_comb begin
        if (smp == MOST_NEG)
            abs_val = MOST_POS;
        else if (smp[SMP_W-1])
            abs_val = SMP_W'(-smp);
        else
            abs_val = smp;
    end

    // Purpose: integrate the magnitude with a shift-based leak on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= '0;
        else if (smp_valid)
            level <= level + ACC_W'(abs_val) - (level >> LSH);
    end

    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LEVEL_CAP);
endmodule

// File: rtl/rssi_magnitude.sv
// Vector length estimate from two smoothed channel levels:
// max(hi, 29/32*hi + 61/128*lo) >> LSH, clamped to a minimum of 1.
// Assumes: levels stay well below 2^ACC_W so the blended sum fits ACC_W+1 bits.
module rssi_magnitude #(
    parameter int ACC_W = 32,
    parameter int LSH   = 8
) (
    input  logic [ACC_W-1:0] lvl_a,
    input  logic [ACC_W-1:0] lvl_b,
    output logic [ACC_W-1:0] length
);
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] hi, lo;
    logic [SUM_W-1:0] blend, pick;
    logic [ACC_W-1:0] scaled;

    // Purpose: order the two levels
    always_comb begin
        if (lvl_a >= lvl_b) begin
            hi = lvl_a;
            lo = lvl_b;
        end else begin
            hi = lvl_b;
            lo = lvl_a;
        end
    end

    // Purpose: shift-and-add weights, each term truncated on its own
    always_comb begin
        blend = SUM_W'(hi >> 1) + SUM_W'(hi >> 2) + SUM_W'(hi >> 3) + SUM_W'(hi >> 5)
              + SUM_W'(lo >> 2) + SUM_W'(lo >> 3) + SUM_W'(lo >> 4) + SUM_W'(lo >> 5)
              + SUM_W'(lo >> 7);
        pick  = (SUM_W'(hi) > blend) ? SUM_W'(hi) : blend;
    end

    // Purpose: scale back down and apply the floor of one
    always_comb begin
        scaled = ACC_W'(pick >> LSH);
        length = (scaled == '0) ? ACC_W'(1) : scaled;
    end
endmodule

// File: rtl/rssi_squant.sv
// Maps an RSSI word to an S-meter code: 1..9 on doubling thresholds,
// then 91..94 on the upper thresholds.
// Assumes: the threshold lists in rssi_pkg are ascending.
module rssi_squant
    import rssi_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic [ACC_W-1:0] rssi_in,
    output scode_t           code
);
    logic [BIN_STEPS-1:0] bin_hit;
    logic [DB_STEPS-1:0]  db_hit;

    // One strict comparator per doubling threshold (4, 8, ... 512)
    for (genvar k = 0; k < BIN_STEPS; k++) begin : g_bin
        assign bin_hit[k] = rssi_in > ACC_W'(64'd1 << (k + BIN_FIRST_EXP));
    end

    // One strict comparator per upper threshold
    for (genvar k = 0; k < DB_STEPS; k++) begin : g_db
        assign db_hit[k] = rssi_in > ACC_W'(DB_LIMIT[k]);
    end

    // Purpose: count thresholds passed and form the code
    always_comb begin
        if (|db_hit)
            code = CODE_W'(DB_BASE_CODE) + CODE_W'($countones(db_hit));
        else
            code = CODE_W'(1) + CODE_W'($countones(bin_hit));
    end
endmodule

// File: rtl/rssi_divider.sv
// Restoring divider, one quotient bit per cycle, N_W cycles per division.
// A start pulse loads the operands; done pulses one cycle after the last step.
// Assumes: denom is nonzero and start is not raised while busy.
module rssi_divider #(
    parameter int N_W = 32,
    parameter int D_W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] numer,
    input  logic [D_W-1:0] denom,
    output logic [N_W-1:0] quot,
    output logic           done
);
    localparam int CNT_W = $clog2(N_W + 1);
    localparam int P_W   = N_W + D_W;

    logic [D_W-1:0]   rem, dvs;
    logic [N_W-1:0]   quo, num_q;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic [D_W:0]     shifted;
    logic             fits;
    logic [D_W-1:0]   rem_nxt;

    // Purpose: one restoring step on the current remainder
    always_comb begin
        shifted = {rem, quo[N_W-1]};
        fits    = shifted >= {1'b0, dvs};
        rem_nxt = fits ? D_W'(shifted - {1'b0, dvs}) : D_W'(shifted);
    end

    // Purpose: load on start, iterate while busy, flag completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            dvs   <= D_W'(1);
            quo   <= '0;
            num_q <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem   <= '0;
                dvs   <= denom;
                quo   <= numer;
                num_q <= numer;
                cnt   <= CNT_W'(N_W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem <= rem_nxt;
                quo <= {quo[N_W-2:0], fits};
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = quo;

    // R3
    nonzero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> denom != '0);

    // R6
    exact_quotient_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((P_W'(quo) * P_W'(dvs) + P_W'(rem) == P_W'(num_q)) && (rem < dvs)));

    // R10
    no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!busy || cnt == CNT_W'(1) || cnt == '0));
endmodule

// File: rtl/rssi_meter.sv
// Top of the signal strength estimator. Per strobe it updates both channel
// integrators. When the transmit flag was low at that strobe, it estimates the
// vector length, divides GAIN_TOP by it and publishes RSSI, S-code and gain
// together with a one-cycle out_valid.
// Assumes: strobes are at least GAIN_W+1 cycles apart.
module rssi_meter
    import rssi_pkg::*;
#(
    parameter int              SMP_W    = 16,
    parameter int              ACC_W    = 32,
    parameter int              LSH      = 8,
    parameter int              GAIN_W   = 32,
    parameter logic [GAIN_W-1:0] GAIN_TOP = GAIN_W'(32'd16777216)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic signed [SMP_W-1:0] smp_q,
    input  logic                    tx_active,
    output logic                    out_valid,
    output logic [ACC_W-1:0]        rssi,
    output logic [CODE_W-1:0]       s_code,
    output logic [GAIN_W-1:0]       rx_gain
);
    localparam int N_CH = 2;

    logic signed [SMP_W-1:0] ch_smp [N_CH];
    logic [ACC_W-1:0]        ch_lvl [N_CH];
    logic [ACC_W-1:0]        length;
    logic [ACC_W-1:0]        cand;
    scode_t                  cand_code;
    logic                    pend, pend_tx;
    logic                    div_start, div_done;
    logic [GAIN_W-1:0]       div_quot;

    assign ch_smp[0] = smp_i;
    assign ch_smp[1] = smp_q;

    // One integrator per channel
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        rssi_level_filter #(
            .SMP_W (SMP_W),
            .ACC_W (ACC_W),
            .LSH   (LSH)
        ) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .smp       (ch_smp[c]),
            .level     (ch_lvl[c])
        );
    end

    rssi_magnitude #(
        .ACC_W (ACC_W),
        .LSH   (LSH)
    ) u_mag (
        .lvl_a  (ch_lvl[0]),
        .lvl_b  (ch_lvl[1]),
        .length (length)
    );

    // Purpose: remember that a strobe happened and what the transmit flag was
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            pend_tx <= 1'b0;
        end else begin
            pend    <= smp_valid;
            pend_tx <= smp_valid & tx_active;
        end
    end

    assign div_start = pend & ~pend_tx;

    // Purpose: capture the new RSSI candidate when a division starts
    always_ff @(posedge clk) begin
        if (!rst_n)
            cand <= ACC_W'(1);
        else if (div_start)
            cand <= length;
    end

    rssi_divider #(
        .N_W (GAIN_W),
        .D_W (ACC_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .numer (GAIN_TOP),
        .denom (length),
        .quot  (div_quot),
        .done  (div_done)
    );

    rssi_squant #(
        .ACC_W (ACC_W)
    ) u_quant (
        .rssi_in (cand),
        .code    (cand_code)
    );

    // Purpose: publish RSSI, code and gain together when the quotient is ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            rssi      <= ACC_W'(1);
            s_code    <= CODE_W'(1);
            rx_gain   <= GAIN_TOP;
        end else begin
            out_valid <= div_done;
            if (div_done) begin
                rssi    <= cand;
                s_code  <= cand_code;
                rx_gain <= div_quot;
            end
        end
    end

    // R3
    rssi_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rssi != '0);

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8
    publish_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rssi, s_code, rx_gain}) |-> out_valid);

    // R5
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_code >= CODE_W'(1) && s_code <= CODE_W'(9)) ||
        (s_code >= CODE_W'(91) && s_code <= CODE_W'(94)));

    // R7
    tx_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && tx_active) |=> !div_start);
endmodule

// File: tb/rssi_meter_tb.sv
// Scoreboard bench: driver tasks push expected results, monitors pop and compare.
module rssi_meter_tb;
    localparam int    GAIN_W = 32;
    localparam longint TOP   = 16777216;
    localparam int    LAT    = GAIN_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int failures = 0;

    // Main instance: default parameters
    logic               m_v = 1'b0, m_tx = 1'b0;
    logic signed [15:0] m_i = '0, m_q = '0;
    logic               m_ov;
    logic [31:0]        m_rssi, m_gain;
    logic [6:0]         m_code;

    // Raw instance: no smoothing, wider samples to reach the top codes
    logic               r_v = 1'b0, r_tx = 1'b0;
    logic signed [19:0] r_i = '0, r_q = '0;
    logic               r_ov;
    logic [31:0]        r_rssi, r_gain;
    logic [6:0]         r_code;

    rssi_meter u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(m_v), .smp_i(m_i), .smp_q(m_q),
        .tx_active(m_tx), .out_valid(m_ov), .rssi(m_rssi), .s_code(m_code), .rx_gain(m_gain)
    );

    rssi_meter #(.SMP_W(20), .LSH(0)) u_dut_raw (
        .clk(clk), .rst_n(rst_n), .smp_valid(r_v), .smp_i(r_i), .smp_q(r_q),
        .tx_active(r_tx), .out_valid(r_ov), .rssi(r_rssi), .s_code(r_code), .rx_gain(r_gain)
    );

    typedef struct {
        longint rssi;
        int     code;
        longint gain;
        longint cyc;
        string  rq_r;
        string  rq_c;
        string  rq_l;
    } item_t;

    item_t qm[$];
    item_t qr[$];
    longint m_li = 0, m_lq = 0, r_li = 0, r_lq = 0;
    longint m_last = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint absat(input longint x, input int w);
        longint lim = (longint'(1) <<< (w - 1)) - 1;
        longint a = (x < 0) ? -x : x;
        return (a > lim) ? lim : a;
    endfunction

    // Vector length per R2 with the floor of R3
    function automatic longint est(input longint a, input longint b, input int lsh);
        longint hi = (a >= b) ? a : b;
        longint lo = (a >= b) ? b : a;
        longint t = (hi >>> 1) + (hi >>> 2) + (hi >>> 3) + (hi >>> 5)
                  + (lo >>> 2) + (lo >>> 3) + (lo >>> 4) + (lo >>> 5) + (lo >>> 7);
        longint m = ((hi > t) ? hi : t) >>> lsh;
        return (m < 1) ? 1 : m;
    endfunction

    // Codes per R4 and R5
    function automatic int code_of(input longint r);
        if (r > 51200) return 94;
        if (r > 16180) return 93;
        if (r > 5120)  return 92;
        if (r > 1618)  return 91;
        for (int n = 9; n >= 2; n--)
            if (r > (longint'(1) <<< n)) return n;
        return 1;
    endfunction

    task automatic send_main(input int i, input int q, input bit tx, input int gap,
                             input string rq);
        item_t it;
        longint r;
        @(negedge clk);
        m_i = 16'(i); m_q = 16'(q); m_tx = tx; m_v = 1'b1;
        m_li = m_li + absat(i, 16) - (m_li >>> 8);
        m_lq = m_lq + absat(q, 16) - (m_lq >>> 8);
        if (!tx) begin
            r = est(m_li, m_lq, 8);
            it.rssi = r; it.code = code_of(r); it.gain = TOP / r;
            it.cyc = cyc + 1 + LAT; it.rq_r = rq;
            it.rq_c = (it.code > 9) ? "R5" : "R4";
            it.rq_l = (gap < 40) ? "R10" : "R8";
            qm.push_back(it);
            m_last = r;
        end
        @(negedge clk);
        m_v = 1'b0; m_tx = 1'b0;
        repeat (gap - 2) @(negedge clk);
        if (tx) begin
            // R7: outputs hold through a transmit-time strobe
            chk(m_rssi == 32'(m_last), "R7", "rssi held during tx", m_rssi, m_last);
            chk(m_gain == 32'(TOP / m_last), "R7", "gain held during tx", m_gain, TOP / m_last);
        end
    endtask

    task automatic send_raw(input int i, input int q, input int gap, input string rq);
        item_t it;
        longint r;
        @(negedge clk);
        r_i = 20'(i); r_q = 20'(q); r_tx = 1'b0; r_v = 1'b1;
        r_li = r_li + absat(i, 20) - r_li;
        r_lq = r_lq + absat(q, 20) - r_lq;
        r = est(r_li, r_lq, 0);
        it.rssi = r; it.code = code_of(r); it.gain = TOP / r;
        it.cyc = cyc + 1 + LAT; it.rq_r = rq;
        it.rq_c = (it.code > 9) ? "R5" : "R4";
        it.rq_l = (gap < 40) ? "R10" : "R8";
        qr.push_back(it);
        @(negedge clk);
        r_v = 1'b0;
        repeat (gap - 2) @(negedge clk);
    endtask

    // Monitor for the main instance
    bit m_prev = 1'b0;
    item_t mit;
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_ov && m_prev) chk(1'b0, "R8", "out_valid wider than one cycle", 2, 1);
            if (m_ov) begin
                if (qm.size() == 0) chk(1'b0, "R7", "unexpected out_valid", 1, 0);
                else begin
                    mit = qm.pop_front();
                    chk(m_rssi == 32'(mit.rssi), mit.rq_r, "rssi", m_rssi, mit.rssi);
                    chk(m_code == 7'(mit.code), mit.rq_c, "s_code", m_code, mit.code);
                    chk(m_gain == 32'(mit.gain), "R6", "rx_gain", m_gain, mit.gain);
                    chk(cyc == mit.cyc, mit.rq_l, "publish cycle", cyc, mit.cyc);
                end
            end
        end
        m_prev = m_ov;
    end

    // Monitor for the raw instance
    bit r_prev = 1'b0;
    item_t rit;
    always @(negedge clk) begin
        if (rst_n) begin
            if (r_ov && r_prev) chk(1'b0, "R8", "raw out_valid wider than one cycle", 2, 1);
            if (r_ov) begin
                if (qr.size() == 0) chk(1'b0, "R7", "raw unexpected out_valid", 1, 0);
                else begin
                    rit = qr.pop_front();
                    chk(r_rssi == 32'(rit.rssi), rit.rq_r, "raw rssi", r_rssi, rit.rssi);
                    chk(r_code == 7'(rit.code), rit.rq_c, "raw s_code", r_code, rit.code);
                    chk(r_gain == 32'(rit.gain), "R6", "raw rx_gain", r_gain, rit.gain);
                    chk(cyc == rit.cyc, rit.rq_l, "raw publish cycle", cyc, rit.cyc);
                end
            end
        end
        r_prev = r_ov;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(m_rssi == 32'd1, "R9", "reset rssi", m_rssi, 1);
        chk(m_code == 7'd1, "R9", "reset s_code", m_code, 1);
        chk(m_gain == 32'(TOP), "R9", "reset rx_gain", m_gain, TOP);
        chk(m_ov == 1'b0, "R9", "reset out_valid", m_ov, 0);
        chk(r_rssi == 32'd1, "R9", "raw reset rssi", r_rssi, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: ramp-up of the smoothed levels
        for (int n = 0; n < 300; n++) send_main(12000, -5000, 1'b0, 40, "R1");
        // R7: transmit-time strobes, levels still integrate
        for (int n = 0; n < 60; n++) send_main(30000, 30000, 1'b1, 40, "R7");
        send_main(1000, 0, 1'b0, 40, "R7");
        // R1: saturating most negative input
        for (int n = 0; n < 200; n++) send_main(-32768, 300, 1'b0, 40, "R1");
        // R10: strobe on the publish edge and one cycle before it
        for (int n = 0; n < 30; n++) send_main(0, 0, 1'b0, (n % 2 == 0) ? 34 : 33, "R1");
        repeat (60) @(negedge clk);

        // Threshold edges on the unsmoothed instance
        send_raw(0, 0, 40, "R3");
        send_raw(4, 0, 40, "R2");
        send_raw(5, 0, 40, "R2");
        send_raw(-9, 0, 40, "R2");
        send_raw(512, 0, 40, "R2");
        send_raw(513, 0, 40, "R2");
        send_raw(1618, 0, 34, "R2");
        send_raw(1619, 0, 33, "R2");
        send_raw(5120, 0, 34, "R2");
        send_raw(5121, 0, 40, "R2");
        send_raw(16180, 0, 40, "R2");
        send_raw(16181, 0, 40, "R2");
        send_raw(51200, 0, 40, "R2");
        send_raw(51201, 0, 40, "R2");
        send_raw(-524288, 0, 40, "R1");
        send_raw(300, 200, 40, "R2");
        send_raw(100, -100, 40, "R2");
        send_raw(0, -700, 40, "R2");
        send_raw(40000, 30000, 40, "R2");
        send_raw(0, 0, 40, "R3");
        repeat (60) @(negedge clk);

        chk(qm.size() == 0, "R8", "main results outstanding", qm.size(), 0);
        chk(qr.size() == 0, "R8", "raw results outstanding", qr.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule